// File: doc/BRIEF.md
# Dual-Mode Address/Data Port

This block sits between a processor's internal bus and a group of eight bidirectional pads. The pads do one of two jobs. In general-purpose mode the pads are open-drain: an output latch, written by the processor, can only pull a pad low. A latch bit of one releases the pad, so the pad can be read as an input. In bus mode the same pads carry a multiplexed external-memory address/data value and drive it push-pull, with no need for an outside pull-up.

Each pad is modelled as three logic signals: a pull-down enable, a pull-up enable and a sampled input level. The processor can load the latch a whole byte at a time, or one bit at a time without touching the other bits. Two read strobes bring data back to the internal bus. One returns the pad levels. The other returns the latch contents, which read-modify-write sequences need.

Top module: `adport_top`

## Requirements
- R1: While reset is low and just after it, the latch holds all ones, every pull-down and pull-up enable is 0, and the read data is 0.
- R2: When `byte_we` is 1 at a clock edge, the latch takes `byte_wdata`.
- R3: When `bit_we` is 1 at a clock edge, only latch bit `bit_idx` takes `bit_wval`, where index 0 is the least significant pad and 7 the most significant. The other seven bits keep their values.
- R4: When `byte_we` and `bit_we` are both 1 in the same cycle, the selected bit takes `bit_wval` and the other bits take `byte_wdata`.
- R5: With `bus_sel` = 0 (general-purpose mode), every pull-up enable is 0. Pull-down enable bit i equals the inverse of latch bit i.
- R6: With `bus_sel` = 1 (bus mode), each pad is driven from `addr_data`. A 0 bit sets only its pull-down enable, and a 1 bit sets only its pull-up enable. The latch contents are not changed by the mode.
- R7: On no bit are the pull-up and pull-down enables both 1, in either mode.
- R8: A `rd_pad` strobe at a clock edge makes `rdata` equal to `pad_in` as it was sampled at that edge, from the next cycle on.
- R9: A `rd_lat` strobe at a clock edge makes `rdata` equal to the latch contents before any write in that same cycle, from the next cycle on.
- R10: If `rd_pad` and `rd_lat` are both 1 in the same cycle, the pad levels are returned.
- R11: With neither read strobe active, `rdata` keeps its value, even when the pads or the latch change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_we | input | 1 | Load the whole latch |
| byte_wdata | input | 8 | Latch value for a byte load |
| bit_we | input | 1 | Load one latch bit |
| bit_idx | input | 3 | Index of the bit to load (0 = LSB) |
| bit_wval | input | 1 | Value for the single-bit load |
| bus_sel | input | 1 | 0 = general-purpose open-drain, 1 = address/data bus |
| addr_data | input | 8 | Address/data value to drive in bus mode |
| rd_pad | input | 1 | Strobe: return the pad levels |
| rd_lat | input | 1 | Strobe: return the latch contents |
| pad_in | input | 8 | Sampled pad levels |
| pd_en | output | 8 | Pull-down driver enables |
| pu_en | output | 8 | Pull-up driver enables |
| rdata | output | 8 | Read data toward the internal bus |

## Verification
The assertions check the following on every cycle:
- The drivers never contend, and general-purpose mode never enables a pull-up.
- In bus mode each bit has exactly one driver enabled.
- A single-bit write leaves the unselected bits alone.
- Both read paths return the right data, and `rdata` holds when no strobe is active.

Some behaviour only shows at the pads, and only through the bench's scenarios:
- A released pad reads back the external level while a latched zero reads back as 0. The bench models the external level with its own float value.
- Both writes in one cycle merge as R4 requires.
- A period in bus mode leaves the latch unchanged.

// File: rtl/adport_pkg.sv
package adport_pkg;

  // Pad function selected by the mode control
  typedef enum logic {
    MODE_GPIO = 1'b0,
    MODE_BUS  = 1'b1
  } pad_mode_e;

  // Source chosen for the read-data register
  typedef enum logic [1:0] {
    RSRC_HOLD  = 2'd0,
    RSRC_PAD   = 2'd1,
    RSRC_LATCH = 2'd2
  } rd_src_e;

endpackage

// File: rtl/adport_latch.sv
module adport_latch #(
  parameter int W = 8,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_we,
  input  logic [W-1:0]  byte_wdata,
  input  logic          bit_we,
  input  logic [SW-1:0] bit_idx,
  input  logic          bit_wval,
  output logic [W-1:0]  q
);

  logic [W-1:0] q_nxt;
  logic         q_ld;

  // Next-state: byte load first, then the single-bit load overrides its bit
  always_comb begin
    q_nxt = q;
    if (byte_we) q_nxt = byte_wdata;
    for (int i = 0; i < W; i++) begin
      if (bit_we && (int'(bit_idx) == i)) q_nxt[i] = bit_wval;
    end
  end

  assign q_ld = byte_we | bit_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '1;
    else if (q_ld) q <= q_nxt;
  end

  assert_byte_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && !bit_we) |=> (q == $past(byte_wdata)));

  assert_bit_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !byte_we) |=>
      (((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0));

  assert_bit_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_we |=> (q[$past(bit_idx)] == $past(bit_wval)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_we && !bit_we) |=> $stable(q));

endmodule

// File: rtl/adport_drive.sv
module adport_drive
  import adport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pad_mode_e    mode,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] addr_data,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] pu_en
);

  // One driver pair per pad
  for (genvar g = 0; g < W; g++) begin : g_pad
    logic drv_lvl;
    logic drv_push;

    always_comb begin
      if (mode == MODE_BUS) begin
        drv_lvl  = addr_data[g];
        drv_push = 1'b1;
      end else begin
        drv_lvl  = lat_q[g];
        drv_push = 1'b0;
      end
    end

    assign pd_en[g] = ~drv_lvl;
    assign pu_en[g] = drv_lvl & drv_push;
  end

  assert_gpio_no_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_GPIO) |-> (pu_en == '0));

  assert_bus_one_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BUS) |-> ((pu_en ^ pd_en) == '1));

  assert_bus_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BUS) |-> (pu_en == addr_data));

endmodule

// File: rtl/adport_rdback.sv
module adport_rdback
  import adport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_pad,
  input  logic         rd_lat,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] lat_q,
  output logic [W-1:0] rdata
);

  rd_src_e      src;
  logic [W-1:0] rdata_nxt;
  logic         rdata_ld;

  // Pad read takes priority over latch read
  always_comb begin
    if (rd_pad)      src = RSRC_PAD;
    else if (rd_lat) src = RSRC_LATCH;
    else             src = RSRC_HOLD;
  end

  always_comb begin
    case (src)
      RSRC_PAD:   rdata_nxt = pad_in;
      RSRC_LATCH: rdata_nxt = lat_q;
      default:    rdata_nxt = rdata;
    endcase
  end

  assign rdata_ld = (src != RSRC_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rdata_ld) rdata <= rdata_nxt;
  end

  assert_pad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pad |=> (rdata == $past(pad_in)));

  assert_latch_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lat && !rd_pad) |=> (rdata == $past(lat_q)));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_pad && !rd_lat) |=> $stable(rdata));

endmodule

// File: rtl/adport_top.sv
module adport_top
  import adport_pkg::*;
#(
  parameter int W = 8,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_we,
  input  logic [W-1:0]  byte_wdata,
  input  logic          bit_we,
  input  logic [SW-1:0] bit_idx,
  input  logic          bit_wval,
  input  logic          bus_sel,
  input  logic [W-1:0]  addr_data,
  input  logic          rd_pad,
  input  logic          rd_lat,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pd_en,
  output logic [W-1:0]  pu_en,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] lat_q;
  pad_mode_e    mode;

  assign mode = pad_mode_e'(bus_sel);

  adport_latch #(.W(W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_we    (byte_we),
    .byte_wdata (byte_wdata),
    .bit_we     (bit_we),
    .bit_idx    (bit_idx),
    .bit_wval   (bit_wval),
    .q          (lat_q)
  );

  adport_drive #(.W(W)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .lat_q     (lat_q),
    .addr_data (addr_data),
    .pd_en     (pd_en),
    .pu_en     (pu_en)
  );

  adport_rdback #(.W(W)) u_rdback (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_pad (rd_pad),
    .rd_lat (rd_lat),
    .pad_in (pad_in),
    .lat_q  (lat_q),
    .rdata  (rdata)
  );

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_en & pd_en) == '0));

  assert_read_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pad && rd_lat) |=> (rdata == $past(pad_in)));

endmodule

// File: tb/sim_adport_top.sv
module sim_adport_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_we, bit_we, bit_wval, bus_sel, rd_pad, rd_lat;
  logic [7:0] byte_wdata, addr_data, pad_in, pd_en, pu_en, rdata;
  logic [2:0] bit_idx;
  logic [7:0] float_lvl;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  // Pad model: a driver wins, otherwise the external float level
  always_comb begin
    for (int i = 0; i < 8; i++)
      pad_in[i] = pd_en[i] ? 1'b0 : (pu_en[i] ? 1'b1 : float_lvl[i]);
  end

  adport_top u0 (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_wdata(byte_wdata),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_wval(bit_wval),
    .bus_sel(bus_sel), .addr_data(addr_data), .rd_pad(rd_pad),
    .rd_lat(rd_lat), .pad_in(pad_in), .pd_en(pd_en), .pu_en(pu_en),
    .rdata(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic no_fight();
    chk("R7", pu_en & pd_en, 8'h00);
  endtask

  // All helpers start and end at a falling edge
  task automatic byte_wr(input logic [7:0] v);
    byte_we = 1'b1; byte_wdata = v;
    @(negedge clk); byte_we = 1'b0;
  endtask

  task automatic bit_wr(input logic [2:0] s, input logic v);
    bit_we = 1'b1; bit_idx = s; bit_wval = v;
    @(negedge clk); bit_we = 1'b0;
  endtask

  task automatic read_latch();
    rd_lat = 1'b1;
    @(negedge clk); rd_lat = 1'b0;
  endtask

  task automatic read_pad();
    rd_pad = 1'b1;
    @(negedge clk); rd_pad = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pd", pd_en, 8'h00);
    chk("R1 pu", pu_en, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after", rdata, 8'h00);
    read_latch();
    chk("R1 latch", rdata, 8'hFF);
  endtask

  task automatic t_byte();
    byte_wr(8'hC3);
    read_latch();
    chk("R2 C3", rdata, 8'hC3);
    byte_wr(8'h3C);
    read_latch();
    chk("R2 3C", rdata, 8'h3C);
  endtask

  task automatic t_bit();
    byte_wr(8'h00);
    bit_wr(3'd0, 1'b1);
    read_latch();
    chk("R3 lsb", rdata, 8'h01);
    bit_wr(3'd7, 1'b1);
    read_latch();
    chk("R3 msb", rdata, 8'h81);
    bit_wr(3'd0, 1'b0);
    read_latch();
    chk("R3 clear", rdata, 8'h80);
  endtask

  task automatic t_both();
    byte_we = 1'b1; byte_wdata = 8'hF0;
    bit_we = 1'b1; bit_idx = 3'd5; bit_wval = 1'b0;
    @(negedge clk); byte_we = 1'b0; bit_we = 1'b0;
    read_latch();
    chk("R4 merge", rdata, 8'hD0);
  endtask

  task automatic t_gpio();
    bus_sel = 1'b0;
    byte_wr(8'h0F);
    chk("R5 pu", pu_en, 8'h00);
    chk("R5 pd", pd_en, 8'hF0);
    no_fight();
    float_lvl = 8'hFF;
    read_pad();
    chk("R8 float high", rdata, 8'h0F);
    float_lvl = 8'h00;
    read_pad();
    chk("R8 float low", rdata, 8'h00);
  endtask

  task automatic t_bus();
    byte_wr(8'h96);
    bus_sel = 1'b1; addr_data = 8'h5A; float_lvl = 8'h00;
    #1;
    chk("R6 pu", pu_en, 8'h5A);
    chk("R6 pd", pd_en, 8'hA5);
    no_fight();
    read_pad();
    chk("R6 pad", rdata, 8'h5A);
    addr_data = 8'hFF;
    #1;
    chk("R6 all high", pu_en, 8'hFF);
    no_fight();
    read_latch();
    chk("R6 latch kept", rdata, 8'h96);
    bus_sel = 1'b0;
    #1;
    chk("R6 back gpio", pd_en, 8'h69);
    chk("R5 no pu", pu_en, 8'h00);
  endtask

  task automatic t_priority();
    byte_wr(8'hAA);
    float_lvl = 8'h00;
    rd_pad = 1'b1; rd_lat = 1'b1;
    @(negedge clk); rd_pad = 1'b0; rd_lat = 1'b0;
    chk("R10 pin wins", rdata, 8'h00);
    byte_we = 1'b1; byte_wdata = 8'h11; rd_lat = 1'b1;
    @(negedge clk); byte_we = 1'b0; rd_lat = 1'b0;
    chk("R9 old latch", rdata, 8'hAA);
  endtask

  task automatic t_hold();
    read_latch();
    chk("R9 latch", rdata, 8'h11);
    float_lvl = 8'hFF;
    byte_wr(8'hFF);
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, 8'h11);
  endtask

  initial begin
    rst_n = 1'b0; byte_we = 1'b0; bit_we = 1'b0; bit_wval = 1'b0;
    bus_sel = 1'b0; rd_pad = 1'b0; rd_lat = 1'b0;
    byte_wdata = 8'h00; addr_data = 8'h00; bit_idx = 3'd0;
    float_lvl = 8'hFF;
    @(negedge clk);
    t_reset();
    t_byte();
    t_bit();
    t_both();
    t_gpio();
    t_bus();
    t_priority();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule